// File: doc/BRIEF.md
# Receive Frame Slip Buffer

This block sits between the recovered line data and the system bus of a receive path. It holds two frames of byte slots in a ring. The line side writes bytes on its own extracted clock. A frame pulse on that side aligns each new frame to the start of a frame half. The system side reads bytes on the system clock. A frame pulse on that side starts each new frame.

The two clocks are nominally locked but may wander against each other. At every read frame start, the block measures the write pointer's lead over the base of the next read frame. The write pointer reaches the read domain through a Gray-coded synchronizer. If the lead is too small, the frame just read is read again (a repeat). If the lead is too large, the next frame is skipped (a drop). Either way the read pointer moves by exactly one frame, and only on a frame boundary.

A toggling status bit and a direction bit record each slip. A one-cycle interrupt pulse flags the slip unless the mask input is high.

Top module: `rx_slip_buf`

## Requirements
- R1: After reset, `slip_flag`, `slip_dir` and `slip_irq` are 0. The read pointer sits one frame behind, so the first read frame is taken from the lower half (addresses 0 to FRAME_SLOTS-1).
- R2: Each `wr_en` stores `wr_data` at the write pointer and advances it by one, wrapping at 2*FRAME_SLOTS. When `wr_frame` is high with `wr_en` and the pointer is not at a half start, the byte goes to the start of the other half instead.
- R3: Each `rd_en` presents the addressed byte on `rd_data` one `rd_clk` cycle later. Reads within a frame take consecutive addresses. A frame start without a slip moves reading to the other half.
- R4: Slip decisions are taken only on a cycle with `rd_en` and `rd_frame` both high. The lead is (synchronized write pointer − base of the next half) modulo 2*FRAME_SLOTS.
- R5: A lead below NEAR_LIM (default 2) repeats the frame just read, and `slip_dir` becomes 1 (underflow).
- R6: A lead above FAR_LIM (default 48) drops one frame, and `slip_dir` becomes 0 (overflow).
- R7: A lead from NEAR_LIM to FAR_LIM inclusive causes no slip, including exactly 2 and exactly 48.
- R8: `slip_flag` inverts on every slip and at no other time. `slip_dir` changes only together with `slip_flag`.
- R9: `slip_irq` pulses high for one `rd_clk` cycle right after a slipping frame start, only when `irq_mask` was 0 on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Extracted line clock |
| rd_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en | input | 1 | Write strobe for one byte |
| wr_frame | input | 1 | Marks the first byte of a line frame |
| wr_data | input | DATA_W | Line byte |
| rd_en | input | 1 | Read strobe for one slot |
| rd_frame | input | 1 | Marks the first slot of a system frame |
| rd_data | output | DATA_W | Byte read, valid one cycle after rd_en |
| irq_mask | input | 1 | High suppresses the slip interrupt |
| slip_flag | output | 1 | Inverts on every slip |
| slip_dir | output | 1 | 1 = frame repeated, 0 = frame dropped |
| slip_irq | output | 1 | One-cycle slip interrupt pulse |

## Verification
The bench places the lead exactly on the limits: 1 and 0 to force repeats, 49 to force a drop, and 2 and 48 to show that no slip occurs. A design with an off-by-one compare would slip on a boundary, or miss one, and the frame it then reads would carry the wrong first byte. The bench also sets the lead to 33 at a wrap of the pointer arithmetic. This catches a lead computed in the wrong direction, which would fire spurious slips there. A masked drop checks that the status still records the slip while the interrupt stays quiet. A mid-frame write frame pulse checks the realignment of the write pointer to the next half.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

  localparam logic DIR_OVERFLOW  = 1'b0;
  localparam logic DIR_UNDERFLOW = 1'b1;
endpackage

// File: rtl/rsb_rst_sync.sv
module rsb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/rsb_wr_side.sv
module rsb_wr_side #(
  parameter int SLOT_W = 5,
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_frame,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_gray
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] gray_q, gray_d;
  logic              at_half_start;

  always_comb begin
    at_half_start = (ptr_q[SLOT_W-1:0] == '0);
    if (wr_frame && !at_half_start) begin
      wr_addr = {~ptr_q[ADDR_W-1], {SLOT_W{1'b0}}};
    end else begin
      wr_addr = ptr_q;
    end
    ptr_d  = wr_en ? (wr_addr + ADDR_W'(1)) : ptr_q;
    gray_d = ptr_d ^ (ptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= gray_d;
    end
  end

  assign wr_gray = gray_q;
endmodule

// File: rtl/rsb_ptr_sync.sv
module rsb_ptr_sync #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] gray_in,
  output logic [ADDR_W-1:0] bin_out
);
  logic [ADDR_W-1:0] meta_q;
  logic [ADDR_W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[ADDR_W-1] = sync_q[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/rsb_mem.sv
module rsb_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= store[rd_addr];
    end
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/rsb_rd_ctrl.sv
module rsb_rd_ctrl
  import rsb_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int NEAR_LIM = 2,
  parameter int FAR_LIM  = 48,
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_frame,
  input  logic              irq_mask,
  input  logic [ADDR_W-1:0] wr_ptr_sync,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              slip_flag,
  output logic              slip_dir,
  output logic              slip_irq
);
  localparam logic [ADDR_W-1:0] NEAR_V = ADDR_W'(NEAR_LIM);
  localparam logic [ADDR_W-1:0] FAR_V  = ADDR_W'(FAR_LIM);

  logic              half_q, half_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              flag_q, flag_d;
  logic              dir_q, dir_d;
  logic              irq_q, irq_d;
  logic [ADDR_W-1:0] next_base;
  logic [ADDR_W-1:0] lead;
  logic              frame_start;
  logic              start_half;
  logic              slip_ev;
  slip_e             kind;

  always_comb begin
    frame_start = rd_en && rd_frame;
    next_base   = {~half_q, {SLOT_W{1'b0}}};
    lead        = wr_ptr_sync - next_base;
    if (lead < NEAR_V) begin
      kind = SLIP_REPEAT;
    end else if (lead > FAR_V) begin
      kind = SLIP_DROP;
    end else begin
      kind = SLIP_NONE;
    end
    start_half = (kind == SLIP_NONE) ? ~half_q : half_q;
    if (frame_start) begin
      rd_addr = {start_half, {SLOT_W{1'b0}}};
    end else begin
      rd_addr = {half_q, slot_q};
    end
    slip_ev = frame_start && (kind != SLIP_NONE);
  end

  always_comb begin
    half_d = half_q;
    slot_d = slot_q;
    if (rd_en) begin
      half_d = rd_addr[ADDR_W-1];
      slot_d = rd_addr[SLOT_W-1:0] + SLOT_W'(1);
    end
    flag_d = flag_q ^ slip_ev;
    dir_d  = dir_q;
    if (slip_ev) begin
      dir_d = (kind == SLIP_REPEAT) ? DIR_UNDERFLOW : DIR_OVERFLOW;
    end
    irq_d = slip_ev && !irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b1;
      slot_q <= '0;
      flag_q <= 1'b0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      slot_q <= slot_d;
      flag_q <= flag_d;
      dir_q  <= dir_d;
      irq_q  <= irq_d;
    end
  end

  assign slip_flag = flag_q;
  assign slip_dir  = dir_q;
  assign slip_irq  = irq_q;
endmodule

// File: rtl/rx_slip_buf.sv
module rx_slip_buf #(
  parameter int DATA_W      = 8,
  parameter int FRAME_SLOTS = 32,
  parameter int NEAR_LIM    = 2,
  parameter int FAR_LIM     = 48
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_frame,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_frame,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_mask,
  output logic              slip_flag,
  output logic              slip_dir,
  output logic              slip_irq
);
  localparam int SLOT_W = $clog2(FRAME_SLOTS);
  localparam int ADDR_W = SLOT_W + 1;

  logic              wr_rst_s;
  logic              rd_rst_s;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] wr_gray;
  logic [ADDR_W-1:0] wr_ptr_sync;
  logic [ADDR_W-1:0] rd_addr;

  rsb_rst_sync u_wr_rst (.clk(wr_clk), .rst_n_in(rst_n), .rst_n_out(wr_rst_s));
  rsb_rst_sync u_rd_rst (.clk(rd_clk), .rst_n_in(rst_n), .rst_n_out(rd_rst_s));

  rsb_wr_side #(.SLOT_W(SLOT_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .wr_en(wr_en), .wr_frame(wr_frame),
    .wr_addr(wr_addr), .wr_gray(wr_gray)
  );

  rsb_ptr_sync #(.ADDR_W(ADDR_W)) u_sync (
    .clk(rd_clk), .rst_n(rd_rst_s), .gray_in(wr_gray), .bin_out(wr_ptr_sync)
  );

  rsb_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_s), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  rsb_rd_ctrl #(.SLOT_W(SLOT_W), .NEAR_LIM(NEAR_LIM), .FAR_LIM(FAR_LIM)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .rd_en(rd_en), .rd_frame(rd_frame),
    .irq_mask(irq_mask), .wr_ptr_sync(wr_ptr_sync), .rd_addr(rd_addr),
    .slip_flag(slip_flag), .slip_dir(slip_dir), .slip_irq(slip_irq)
  );
endmodule

// File: rtl/rx_slip_buf_chk.sv
module rx_slip_buf_chk (
  input logic rd_clk,
  input logic rd_rst_n,
  input logic rd_en,
  input logic rd_frame,
  input logic irq_mask,
  input logic slip_flag,
  input logic slip_dir,
  input logic slip_irq
);
  // R4, R8: the flag moves only after a read frame start
  p_flag_at_frame_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && rd_frame) |=> $stable(slip_flag));

  // R8: direction changes only together with the flag
  p_dir_with_flag_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $stable(slip_flag) |-> $stable(slip_dir));

  // R9: no interrupt when the mask was high
  p_irq_unmasked_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_irq |-> $past(!irq_mask));

  // R9: an interrupt comes only with a slip
  p_irq_on_slip_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_irq |-> !$stable(slip_flag));
endmodule

bind rx_slip_buf rx_slip_buf_chk u_chk (
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_s), .rd_en(rd_en), .rd_frame(rd_frame),
  .irq_mask(irq_mask), .slip_flag(slip_flag), .slip_dir(slip_dir),
  .slip_irq(slip_irq)
);

// File: tb/rx_slip_buf_tb.sv
module rx_slip_buf_tb;
  localparam int CLK_PERIOD = 8;
  localparam int WR_PERIOD  = 10;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [15:0] n_wr;
    logic        mask;
    logic        flag;
    logic        dir;
    logic        irq;
    logic        seq;
    logic [7:0]  first;
  } vec_t;

  // writes before the read frame, mask, expected flag/dir/irq, consecutive data, first byte
  localparam vec_t VECS [NVEC] = '{
    '{16'd33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0},   // lead 33, no slip (R7)
    '{16'd32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd32},  // lead 33 across the wrap (R4)
    '{16'd31, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd64},  // lead 32
    '{16'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd64},  // lead 1: repeat (R5)
    '{16'd32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd96},  // lead 33
    '{16'd48, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd160}, // lead 49: masked drop (R6)
    '{16'd32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd192}, // lead 17
    '{16'd17, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd224}, // lead 2 boundary (R7)
    '{16'd14, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd192}, // lead 48 boundary (R7)
    '{16'd48, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0}    // lead 0: repeat (R5)
  };

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       wr_frame;
  logic [7:0] wr_data;
  logic       rd_en;
  logic       rd_frame;
  logic [7:0] rd_data;
  logic       irq_mask;
  logic       slip_flag;
  logic       slip_dir;
  logic       slip_irq;

  int checks = 0;
  int errors = 0;
  int wcnt   = 0;
  int irq_total = 0;
  bit done = 0;
  logic [7:0] rbuf [32];

  always #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  always #(CLK_PERIOD / 2) rd_clk = ~rd_clk;

  always @(negedge rd_clk) if (slip_irq === 1'b1) irq_total++;

  rx_slip_buf u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_frame(wr_frame), .wr_data(wr_data), .rd_en(rd_en), .rd_frame(rd_frame),
    .rd_data(rd_data), .irq_mask(irq_mask), .slip_flag(slip_flag),
    .slip_dir(slip_dir), .slip_irq(slip_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d, input logic fr);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_frame = fr; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0; wr_frame = 1'b0;
  endtask

  task automatic write_run(input int n);
    for (int i = 0; i < n; i++) begin
      write_byte(8'(wcnt), (wcnt % 32) == 0);
      wcnt++;
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) @(negedge rd_clk);
  endtask

  task automatic read_frame();
    for (int i = 0; i < 32; i++) begin
      rd_en = 1'b1; rd_frame = (i == 0);
      @(negedge rd_clk);
      rbuf[i] = rd_data;
    end
    rd_en = 1'b0; rd_frame = 1'b0;
    @(negedge rd_clk);
    @(negedge rd_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge wr_clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) @(negedge wr_clk);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int irq_before;
    wr_en = 0; wr_frame = 0; wr_data = 0; rd_en = 0; rd_frame = 0; irq_mask = 0;
    do_reset();

    // R1: reset state
    check("R1 flag", int'(slip_flag), 0);
    check("R1 dir", int'(slip_dir), 0);
    check("R1 irq", int'(slip_irq), 0);

    for (int v = 0; v < NVEC; v++) begin
      write_run(int'(VECS[v].n_wr));
      settle();
      @(negedge rd_clk);
      irq_mask = VECS[v].mask;
      irq_before = irq_total;
      read_frame();
      // R3 R5 R6 R7: first byte tells which half was read
      check($sformatf("R3/R5/R6/R7 vec%0d first", v), int'(rbuf[0]), int'(VECS[v].first));
      check($sformatf("R8 vec%0d flag", v), int'(slip_flag), int'(VECS[v].flag));
      check($sformatf("R8 vec%0d dir", v), int'(slip_dir), int'(VECS[v].dir));
      check($sformatf("R9 vec%0d irq", v), irq_total - irq_before, int'(VECS[v].irq));
      if (VECS[v].seq) begin
        for (int i = 1; i < 32; i++) begin
          check($sformatf("R3 vec%0d byte%0d", v, i), int'(rbuf[i]), int'(8'(VECS[v].first + 8'(i))));
        end
      end
      irq_mask = 1'b0;
    end

    // R2: mid-frame frame pulse realigns the write pointer to the next half
    do_reset();
    // R1: first frame after reset comes from the lower half
    for (int i = 0; i < 5; i++) write_byte(8'(8'h10 + i), i == 0);
    write_byte(8'hAA, 1'b1);
    for (int i = 0; i < 3; i++) write_byte(8'(8'hAB + i), 1'b0);
    settle();
    @(negedge rd_clk);
    read_frame();
    check("R1 lower half byte0", int'(rbuf[0]), 8'h10);
    check("R1 lower half byte4", int'(rbuf[4]), 8'h14);
    settle();
    read_frame();
    check("R2 realigned byte", int'(rbuf[0]), 8'hAA);
    check("R2 following byte", int'(rbuf[1]), 8'hAB);
    check("R7 no slip lead 4", int'(slip_flag), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule